// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes one memory instruction issued for a group of 32 lanes. Each lane carries an active bit and a byte address of a 4-byte word. The block works out which aligned memory chunks those addresses touch. It then sends exactly one request per distinct chunk on a downstream valid/ready port. A mode bit given with the instruction sets the chunk size: 128-byte lines for cached loads, or 32-byte segments for uncached loads.

Requests go out in ascending address order, one per cycle while the downstream side is ready. Once the last request has been accepted, the block raises a one-cycle completion pulse. At the same time it publishes the number of requests that instruction produced and the number of bytes those requests move. Only one instruction is in progress at a time. A new one is taken only after every request of the previous one has been sent.

The cache, the memory model and the data return path lie outside this block.

Top module: `warp_coalescer`

## Requirements
- R1: `inst_ready` is high exactly when no instruction is in progress. An instruction is taken on a cycle with `inst_valid` and `inst_ready` both high. `inst_ready` stays low from the next cycle until the cycle after `done`, and `req_valid` is never high while `inst_ready` is high.
- R2: With `inst_mode` = 0 (caching), each request address is the lane byte address with its low 7 bits cleared, which is an aligned 128-byte line.
- R3: With `inst_mode` = 1 (non-caching), each request address is the lane byte address with its low 5 bits cleared, which is an aligned 32-byte segment.
- R4: An instruction produces exactly one request for each distinct chunk touched by its active lanes. Lanes that share a chunk, including lanes that all name the same word, are merged into a single request.
- R5: Within one instruction, requests are issued in strictly ascending address order, whatever the order of the lanes.
- R6: Once `req_valid` is high, it stays high with `req_addr` unchanged until a cycle in which `req_ready` is high. One request completes per cycle in which both are high.
- R7: Lanes whose `inst_active` bit is 0 are ignored. An instruction with no active lanes issues no requests, and `done` is high in the cycle right after it is taken.
- R8: `done` is high for exactly one cycle: the cycle after the final request handshake. In that cycle `req_count` shows the number of requests and `bytes_moved` shows that number times the chunk size (128 or 32). Both hold until the next `done`.
- R9: After reset, `inst_ready` = 1, `req_valid` = 0, `done` = 0, `req_count` = 0 and `bytes_moved` = 0.
- R10: 32 consecutive aligned words give 1 request (128 bytes) in caching mode and 4 requests (128 bytes) in non-caching mode. Starting them 36 bytes past a line boundary gives 2 requests in caching mode and 5 requests in non-caching mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_valid | input | 1 | An instruction is offered |
| inst_ready | output | 1 | Block can take an instruction |
| inst_mode | input | 1 | 0 = 128-byte lines, 1 = 32-byte segments |
| inst_active | input | LANES | Per-lane active bits, lane i at bit i |
| inst_addr | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| req_valid | output | 1 | A chunk request is offered |
| req_ready | input | 1 | Downstream accepts the request |
| req_addr | output | ADDR_W | Aligned byte address of the chunk |
| done | output | 1 | One-cycle pulse after the last request of an instruction |
| req_count | output | CNT_W | Requests issued by the last completed instruction |
| bytes_moved | output | BYTES_W | Bytes covered by those requests |

## Verification
A stale pending lane inside the block shows at the request port within a few cycles. It appears either as an extra request carrying an address already sent, or as an address that fails to rise, in the first handshake after the fault. A lane dropped by mistake shows as a missing address in the request stream and as a low `req_count` at the `done` pulse. A wrong mode latch shows as the wrong alignment and the wrong byte total at `done`. The bench compares every handshake address in order against a sorted set of unique chunks built from the lane addresses. It also checks the pulse timing against the cycle of the last handshake.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_FIN  = 2'd2
    } coal_state_e;

    typedef enum logic {
        GRAN_LINE = 1'b0,
        GRAN_SEG  = 1'b1
    } coal_gran_e;

endpackage

// File: rtl/coal_chunk_map.sv
module coal_chunk_map #(
    parameter int LANES   = 32,
    parameter int ADDR_W  = 32,
    parameter int LINE_SH = 7,
    parameter int SEG_SH  = 5,
    parameter int CIDX_W  = ADDR_W - SEG_SH
) (
    input  logic                           gran_seg,
    input  logic [LANES*ADDR_W-1:0]        lane_addr,
    output logic [LANES-1:0][CIDX_W-1:0]   lane_chunk
);
    localparam int PAD_W = LINE_SH - SEG_SH;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [ADDR_W-1:0] a;
        assign a = lane_addr[g*ADDR_W +: ADDR_W];
        always_comb begin
            if (gran_seg) begin
                lane_chunk[g] = a[ADDR_W-1:SEG_SH];
            end else begin
                lane_chunk[g] = {{PAD_W{1'b0}}, a[ADDR_W-1:LINE_SH]};
            end
        end
    end
endmodule

// File: rtl/coal_min_tree.sv
module coal_min_tree #(
    parameter int LANES  = 32,
    parameter int CIDX_W = 27
) (
    input  logic [LANES-1:0]              pend,
    input  logic [LANES-1:0][CIDX_W-1:0]  chunk,
    output logic                          any,
    output logic [CIDX_W-1:0]             min_chunk
);
    localparam int NODES = 2 * LANES - 1;
    localparam int FIRST_LEAF = LANES - 1;

    logic [NODES-1:0]             nv;
    logic [NODES-1:0][CIDX_W-1:0] nc;

    for (genvar l = 0; l < LANES; l++) begin : g_leaf
        assign nv[FIRST_LEAF+l] = pend[l];
        assign nc[FIRST_LEAF+l] = chunk[l];
    end

    for (genvar n = 0; n < LANES - 1; n++) begin : g_node
        localparam int L = 2 * n + 1;
        localparam int R = 2 * n + 2;
        always_comb begin
            nv[n] = nv[L] | nv[R];
            if (nv[L] && nv[R]) begin
                nc[n] = (nc[R] < nc[L]) ? nc[R] : nc[L];
            end else if (nv[R]) begin
                nc[n] = nc[R];
            end else begin
                nc[n] = nc[L];
            end
        end
    end

    assign any       = nv[0];
    assign min_chunk = nc[0];
endmodule

// File: rtl/coal_match.sv
module coal_match #(
    parameter int LANES  = 32,
    parameter int CIDX_W = 27
) (
    input  logic [LANES-1:0]              pend,
    input  logic [LANES-1:0][CIDX_W-1:0]  chunk,
    input  logic [CIDX_W-1:0]             key,
    output logic [LANES-1:0]              hit
);
    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign hit[g] = pend[g] && (chunk[g] == key);
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128,
    parameter int SEG_BYTES  = 32,
    parameter int CNT_W      = $clog2(LANES + 1),
    parameter int BYTES_W    = $clog2(LANES * LINE_BYTES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      inst_valid,
    output logic                      inst_ready,
    input  logic                      inst_mode,
    input  logic [LANES-1:0]          inst_active,
    input  logic [LANES*ADDR_W-1:0]   inst_addr,
    output logic                      req_valid,
    input  logic                      req_ready,
    output logic [ADDR_W-1:0]         req_addr,
    output logic                      done,
    output logic [CNT_W-1:0]          req_count,
    output logic [BYTES_W-1:0]        bytes_moved
);
    localparam int LINE_SH = $clog2(LINE_BYTES);
    localparam int SEG_SH  = $clog2(SEG_BYTES);
    localparam int CIDX_W  = ADDR_W - SEG_SH;
    localparam int LIDX_W  = ADDR_W - LINE_SH;

    typedef struct packed {
        coal_state_e                  state;
        coal_gran_e                   gran;
        logic [LANES-1:0]             pend;
        logic [LANES-1:0][CIDX_W-1:0] chunk;
        logic [CNT_W-1:0]             cnt;
        logic [CNT_W-1:0]             res_cnt;
        logic [BYTES_W-1:0]           res_bytes;
    } coal_regs_t;

    coal_regs_t r_q, r_d;

    logic [LANES-1:0][CIDX_W-1:0] mapped;
    logic                         any_pend;
    logic [CIDX_W-1:0]            min_chunk;
    logic [LANES-1:0]             hit;
    logic                         hs;
    logic [LANES-1:0]             left;
    logic [CNT_W-1:0]             cnt_inc;

    coal_chunk_map #(
        .LANES(LANES), .ADDR_W(ADDR_W), .LINE_SH(LINE_SH),
        .SEG_SH(SEG_SH), .CIDX_W(CIDX_W)
    ) u_map (
        .gran_seg  (inst_mode),
        .lane_addr (inst_addr),
        .lane_chunk(mapped)
    );

    coal_min_tree #(.LANES(LANES), .CIDX_W(CIDX_W)) u_min (
        .pend     (r_q.pend),
        .chunk    (r_q.chunk),
        .any      (any_pend),
        .min_chunk(min_chunk)
    );

    coal_match #(.LANES(LANES), .CIDX_W(CIDX_W)) u_match (
        .pend (r_q.pend),
        .chunk(r_q.chunk),
        .key  (min_chunk),
        .hit  (hit)
    );

    assign inst_ready  = (r_q.state == ST_IDLE);
    assign req_valid   = (r_q.state == ST_BUSY) && any_pend;
    assign done        = (r_q.state == ST_FIN);
    assign req_count   = r_q.res_cnt;
    assign bytes_moved = r_q.res_bytes;
    assign hs          = req_valid && req_ready;
    assign left        = r_q.pend & ~hit;
    assign cnt_inc     = r_q.cnt + CNT_W'(1);

    always_comb begin
        if (r_q.gran == GRAN_SEG) begin
            req_addr = {min_chunk, {SEG_SH{1'b0}}};
        end else begin
            req_addr = {min_chunk[LIDX_W-1:0], {LINE_SH{1'b0}}};
        end
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (inst_valid) begin
                    r_d.pend  = inst_active;
                    r_d.chunk = mapped;
                    r_d.gran  = coal_gran_e'(inst_mode);
                    r_d.cnt   = '0;
                    if (|inst_active) begin
                        r_d.state = ST_BUSY;
                    end else begin
                        r_d.state     = ST_FIN;
                        r_d.res_cnt   = '0;
                        r_d.res_bytes = '0;
                    end
                end
            end
            ST_BUSY: begin
                if (hs) begin
                    r_d.pend = left;
                    r_d.cnt  = cnt_inc;
                    if (left == '0) begin
                        r_d.state   = ST_FIN;
                        r_d.res_cnt = cnt_inc;
                        if (r_q.gran == GRAN_SEG) begin
                            r_d.res_bytes = BYTES_W'(cnt_inc) << SEG_SH;
                        end else begin
                            r_d.res_bytes = BYTES_W'(cnt_inc) << LINE_SH;
                        end
                    end
                end
            end
            ST_FIN: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, gran: GRAN_LINE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // Observation state for the ordering check
    logic [ADDR_W-1:0] last_addr_q;
    logic              have_last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_addr_q <= '0;
            have_last_q <= 1'b0;
        end else if (inst_valid && inst_ready) begin
            have_last_q <= 1'b0;
        end else if (hs) begin
            last_addr_q <= req_addr;
            have_last_q <= 1'b1;
        end
    end

    // R1
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !inst_ready);

    // R1
    take_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_valid && inst_ready) |=> !inst_ready);

    // R2
    line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && r_q.gran == GRAN_LINE) |-> (req_addr[LINE_SH-1:0] == '0));

    // R3
    seg_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && r_q.gran == GRAN_SEG) |-> (req_addr[SEG_SH-1:0] == '0));

    // R5
    ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && have_last_q) |-> (req_addr > last_addr_q));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

    // R7
    empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_valid && inst_ready && inst_active == '0) |=> done);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);

endmodule

// File: tb/tb_warp_coalescer.sv
module tb_warp_coalescer;
    localparam int LANES   = 32;
    localparam int ADDR_W  = 32;
    localparam int CNT_W   = 6;
    localparam int BYTES_W = 13;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    inst_valid = 1'b0;
    logic                    inst_ready;
    logic                    inst_mode = 1'b0;
    logic [LANES-1:0]        inst_active = '0;
    logic [LANES*ADDR_W-1:0] inst_addr = '0;
    logic                    req_valid;
    logic                    req_ready = 1'b0;
    logic [ADDR_W-1:0]       req_addr;
    logic                    done;
    logic [CNT_W-1:0]        req_count;
    logic [BYTES_W-1:0]      bytes_moved;

    always #2 clk = ~clk;

    warp_coalescer dut (
        .clk(clk), .rst_n(rst_n),
        .inst_valid(inst_valid), .inst_ready(inst_ready),
        .inst_mode(inst_mode), .inst_active(inst_active), .inst_addr(inst_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .done(done), .req_count(req_count), .bytes_moved(bytes_moved)
    );

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [31:0] lane_a [LANES];
    logic [31:0] exp_list [LANES];
    int          exp_n;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<150000", cycles);
            summary();
        end
    end

    // Sorted set of unique chunk addresses among active lanes
    task automatic build_expected(input bit seg, input logic [LANES-1:0] act);
        exp_n = 0;
        for (int i = 0; i < LANES; i++) begin
            if (act[i]) begin
                logic [31:0] c;
                bit          seen;
                c = seg ? {lane_a[i][31:5], 5'b0} : {lane_a[i][31:7], 7'b0};
                seen = 0;
                for (int k = 0; k < exp_n; k++) if (exp_list[k] == c) seen = 1;
                if (!seen) begin
                    exp_list[exp_n] = c;
                    exp_n++;
                end
            end
        end
        for (int i = 0; i < exp_n; i++) begin
            for (int k = 0; k + 1 < exp_n - i; k++) begin
                if (exp_list[k] > exp_list[k+1]) begin
                    logic [31:0] t;
                    t = exp_list[k];
                    exp_list[k] = exp_list[k+1];
                    exp_list[k+1] = t;
                end
            end
        end
    endtask

    task automatic run_inst(input bit seg, input logic [LANES-1:0] act,
                            input int ready_pct, input int want_n);
        int  got;
        int  last_hs;
        bit  prev_stall;
        logic [31:0] prev_addr;
        bit  finished;
        build_expected(seg, act);
        if (want_n >= 0)
            check(exp_n == want_n, "R10", "model chunk count", exp_n, want_n);
        @(negedge clk);
        inst_valid  = 1'b1;
        inst_mode   = seg;
        inst_active = act;
        for (int i = 0; i < LANES; i++) inst_addr[i*ADDR_W +: ADDR_W] = lane_a[i];
        #1;
        check(inst_ready == 1'b1, "R1", "inst_ready when idle", inst_ready, 1);
        got = 0;
        last_hs = -1;
        prev_stall = 0;
        prev_addr = '0;
        finished = 0;
        for (int it = 0; it < 400 && !finished; it++) begin
            @(negedge clk);
            inst_valid = 1'b0;
            req_ready = ($urandom_range(99) < ready_pct);
            #1;
            if (done) begin
                finished = 1;
                check(it == last_hs + 1, "R8", "done cycle after last handshake", it, last_hs + 1);
                if (act == '0)
                    check(it == 0, "R7", "empty instruction done at once", it, 0);
                check(got == exp_n, "R4", "request count seen", got, exp_n);
                check(req_count == CNT_W'(exp_n), "R8", "req_count", req_count, exp_n);
                check(bytes_moved == BYTES_W'(exp_n * (seg ? 32 : 128)), "R8", "bytes_moved",
                      bytes_moved, exp_n * (seg ? 32 : 128));
                if (want_n >= 0)
                    check(req_count == CNT_W'(want_n), "R10", "pattern request count",
                          req_count, want_n);
            end else begin
                check(inst_ready == 1'b0, "R1", "inst_ready while busy", inst_ready, 0);
                if (prev_stall)
                    check(req_valid && req_addr == prev_addr, "R6", "held request",
                          req_addr, prev_addr);
                if (req_valid) begin
                    if (got < exp_n) begin
                        check(req_addr == exp_list[got], seg ? "R3" : "R2",
                              "request address (R5 order)", req_addr, exp_list[got]);
                    end else begin
                        check(0, "R4", "extra request", req_addr, 0);
                    end
                    if (req_ready) begin
                        got++;
                        last_hs = it;
                    end
                end
                prev_stall = req_valid && !req_ready;
                prev_addr = req_addr;
            end
        end
        if (!finished) check(0, "R8", "done never seen", 0, 1);
        @(negedge clk);
        req_ready = 1'b0;
        #1;
        check(done == 1'b0, "R8", "done one cycle wide", done, 0);
        check(inst_ready == 1'b1, "R1", "ready after done", inst_ready, 1);
        check(req_count == CNT_W'(exp_n), "R8", "req_count held", req_count, exp_n);
    endtask

    task automatic fill_linear(input logic [31:0] base);
        for (int i = 0; i < LANES; i++) lane_a[i] = base + 32'(4 * i);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        check(inst_ready == 1'b1, "R9", "inst_ready in reset", inst_ready, 1);
        check(req_valid == 1'b0, "R9", "req_valid in reset", req_valid, 0);
        check(done == 1'b0, "R9", "done in reset", done, 0);
        check(req_count == '0 && bytes_moved == '0, "R9", "counters in reset",
              {req_count, bytes_moved}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 aligned consecutive words
        fill_linear(32'h0000_1000);
        run_inst(1'b0, '1, 100, 1);
        run_inst(1'b1, '1, 60, 4);
        // R5 lanes in reversed order give the same ascending stream
        for (int i = 0; i < LANES; i++) lane_a[i] = 32'h0000_1000 + 32'(4 * (LANES - 1 - i));
        run_inst(1'b1, '1, 50, 4);
        run_inst(1'b0, '1, 50, 1);
        // R10 misaligned by 36 bytes
        fill_linear(32'h0000_1024);
        run_inst(1'b0, '1, 70, 2);
        run_inst(1'b1, '1, 70, 5);
        // R4 every lane on one word
        for (int i = 0; i < LANES; i++) lane_a[i] = 32'h0000_2468;
        run_inst(1'b0, '1, 100, 1);
        run_inst(1'b1, '1, 30, 1);
        // R7 no active lanes, then a single active lane
        fill_linear(32'h0000_4000);
        run_inst(1'b0, '0, 100, 0);
        run_inst(1'b1, 32'h0000_0100, 100, 1);
        // R7 inactive lanes carrying far addresses are ignored
        for (int i = 0; i < LANES; i++) lane_a[i] = (i % 2 == 0) ? 32'h0000_8000 : 32'hFFFF_FF80;
        run_inst(1'b0, 32'h5555_5555, 80, 1);
        // R6 long stalls with scattered addresses
        for (int i = 0; i < LANES; i++) lane_a[i] = 32'(i * 4096 + 4 * i);
        run_inst(1'b1, '1, 15, 32);

        // Random patterns
        for (int n = 0; n < 80; n++) begin
            logic [31:0] base;
            int          span;
            base = $urandom() & 32'hFFFF_FFFC;
            span = (n % 3 == 0) ? 256 : ((n % 3 == 1) ? 2048 : 65536);
            for (int i = 0; i < LANES; i++)
                lane_a[i] = base + 32'($urandom_range(span / 4 - 1) * 4);
            run_inst(n[0], (n % 5 == 0) ? $urandom() : '1, 20 + (n % 4) * 25, -1);
        end

        summary();
    end
endmodule